// File: doc/BRIEF.md
# BCD Clock-Calendar Counter with User Copy

This block keeps time of day and calendar date in packed BCD: hundredths of a second, seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and a century flag with its own enable. It is paced by a base strobe `tick`. A sub-second divider turns every `DIV_RATIO` strobes into one hundredth-of-a-second step, so the strobe runs at `DIV_RATIO` x 100 Hz. With `DIV_RATIO` = 1 the strobe itself is the 100 Hz rate.

The block holds two images of the time. The counting image advances on its own. The user image is the one that reads return. On every strobe the counting image is copied into the user image. That copy is skipped while the bus side asserts `hold`, which it does while it reads clock bytes, so a multi-byte read sees one coherent time. The copy is also skipped while the halt flag is set. The halt flag is set by `power_fail` and stays set until software clears it, so the time of the power loss stays readable. Byte writes land in both images at once. A write also clears the hundredths and restarts the divider.

Both ports are plain strobes with no back-pressure. A write is taken in the cycle `wr_en` is high. `rd_data` follows `rd_addr` combinationally from the user image.

Top module: `rtc_bcd_core`

## Requirements
- R1: A write (`wr_en`=1) to any address 0..7 sets hundredths to 00 and stores the byte. The data written to address 0 is ignored. Byte layouts, with unused bits reading 0:
  - address 0: hundredths (8 bits).
  - address 1: [7] stop bit, [6:0] seconds.
  - address 2: [6:0] minutes.
  - address 3: [7] century enable, [6] century bit, [5:0] hours.
  - address 4: [2:0] day of week, 1..7.
  - address 5: [5:0] date.
  - address 6: [4:0] month.
  - address 7: year.
- R2: A written value can be read back the cycle after the write, whatever the state of `hold` or the halt flag.
- R3: While running, hundredths advance by one on every `DIV_RATIO`-th strobe. A write restarts the divider, so the first step after a write comes on the `DIV_RATIO`-th strobe that follows it. The counting image does not change in cycles with neither a strobe nor a write.
- R4: Counters carry in order. Hundredths wrap 99→00, seconds 59→00, minutes 59→00 and hours 23→00. Each hour wrap also moves day of week from 7 to 1 and advances the date.
- R5: The date wraps to 01 after 30 in months 4, 6, 9 and 11, and after 31 in months 1, 3, 5, 7, 8, 10 and 12. Month 12 wraps to 01 and advances the year.
- R6: February ends on 29 when the year value is a multiple of 4 (00 counts as one), and on 28 otherwise.
- R7: Year wraps 99→00. On that wrap the century bit inverts if the century enable is 1, and is left unchanged if the enable is 0.
- R8: While the stop bit is 1, the counting image and the divider hold still. Clearing the stop bit by a write resumes counting.
- R9: With `hold`, the halt flag and `power_fail` all low, the user image equals the counting image the cycle after each strobe.
- R10: While `hold` is 1, the user image is frozen and the counting image keeps advancing. The first strobe after release refreshes the user image.
- R11: `power_fail` sets the halt flag (`halted`) on the next edge. The flag stays set until `halt_clr` is 1 while `power_fail` is 0. While the flag is set or `power_fail` is high, strobes do not refresh the user image.
- R12: After reset the time reads 00:00:00.00, day 1, date 01, month 01, year 00, with the stop bit, century enable, century bit and halt flag all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base time strobe, DIV_RATIO x 100 Hz |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Clock byte address for a write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 3 | Clock byte address for a read |
| rd_data | output | 8 | User-image byte at rd_addr (combinational) |
| hold | input | 1 | Freeze user image (bus read in progress) |
| power_fail | input | 1 | Power-fail indication; sets the halt flag |
| halt_clr | input | 1 | Clear the halt flag |
| halted | output | 1 | Halt flag |

## Verification
Every stored effect is due one edge after the cycle in which `wr_en`, `tick`, `power_fail` or `halt_clr` is sampled. `rd_data` is combinational and follows `rd_addr` within the same cycle. A behavioural model in the bench applies the same inputs at each rising edge. The bench compares one user byte, stepping through the addresses, and `halted` 1 ns after every rising edge, once all registers have settled. Directed reads set `rd_addr` after a falling edge and sample half a nanosecond later, so they never straddle an edge. The long carry chains are reached by writing a near-rollover time and then applying exactly 100 x `DIV_RATIO` strobes.

// File: rtl/rtc_core_pkg.sv
`timescale 1ns/1ps
package rtc_core_pkg;

  localparam int NUM_BYTES = 8;
  localparam int AW        = $clog2(NUM_BYTES);

  typedef struct packed {
    logic [7:0] hs;
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic       cen_en;
    logic       cen;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{hs: 8'h00, stop: 1'b0, sec: 7'h00, min: 7'h00,
                                      cen_en: 1'b0, cen: 1'b0, hr: 6'h00, dow: 3'd1,
                                      date: 6'h01, mon: 5'h01, yr: 8'h00};

  // {wrapped, next}: BCD increment, wrapping to 'first' at or beyond 'last'
  function automatic logic [8:0] bcd_roll(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v >= last)          return {1'b1, first};
    else if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    else                    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = yr[7:4] * 7'd10 + {3'b000, yr[3:0]};
    case (mon)
      5'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] byte_of(input rtc_time_t t, input logic [AW-1:0] idx);
    case (idx)
      3'd0:    return t.hs;
      3'd1:    return {t.stop, t.sec};
      3'd2:    return {1'b0, t.min};
      3'd3:    return {t.cen_en, t.cen, t.hr};
      3'd4:    return {5'b00000, t.dow};
      3'd5:    return {2'b00, t.date};
      3'd6:    return {3'b000, t.mon};
      default: return t.yr;
    endcase
  endfunction

  function automatic rtc_time_t apply_write(input rtc_time_t t, input logic [AW-1:0] idx,
                                            input logic [7:0] d);
    rtc_time_t r;
    r = t;
    case (idx)
      3'd1: begin r.stop = d[7]; r.sec = d[6:0]; end
      3'd2: r.min = d[6:0];
      3'd3: begin r.cen_en = d[7]; r.cen = d[6]; r.hr = d[5:0]; end
      3'd4: r.dow = d[2:0];
      3'd5: r.date = d[5:0];
      3'd6: r.mon = d[4:0];
      3'd7: r.yr = d;
      default: ;
    endcase
    r.hs = 8'h00;
    return r;
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
`timescale 1ns/1ps
module rtc_subsec_div #(
  parameter int DIV_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clear,
  output logic step
);
  generate
    if (DIV_RATIO <= 1) begin : g_direct
      assign step = tick && run && !clear;
    end else begin : g_count
      localparam int CW = $clog2(DIV_RATIO);
      localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clear)       cnt <= '0;
        else if (tick && run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign step = tick && run && !clear && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/rtc_time_adv.sv
`timescale 1ns/1ps
module rtc_time_adv
  import rtc_core_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic [8:0] r_hs, r_sec, r_min, r_hr, r_dow, r_date, r_mon, r_yr;

  always_comb begin
    nxt    = cur;
    r_hs   = bcd_roll(cur.hs, 8'h99, 8'h00);
    r_sec  = bcd_roll({1'b0, cur.sec}, 8'h59, 8'h00);
    r_min  = bcd_roll({1'b0, cur.min}, 8'h59, 8'h00);
    r_hr   = bcd_roll({2'b00, cur.hr}, 8'h23, 8'h00);
    r_dow  = bcd_roll({5'b00000, cur.dow}, 8'h07, 8'h01);
    r_date = bcd_roll({2'b00, cur.date}, month_last(cur.mon, cur.yr), 8'h01);
    r_mon  = bcd_roll({3'b000, cur.mon}, 8'h12, 8'h01);
    r_yr   = bcd_roll(cur.yr, 8'h99, 8'h00);

    nxt.hs = r_hs[7:0];
    if (r_hs[8]) begin
      nxt.sec = r_sec[6:0];
      if (r_sec[8]) begin
        nxt.min = r_min[6:0];
        if (r_min[8]) begin
          nxt.hr = r_hr[5:0];
          if (r_hr[8]) begin
            nxt.dow  = r_dow[2:0];
            nxt.date = r_date[5:0];
            if (r_date[8]) begin
              nxt.mon = r_mon[4:0];
              if (r_mon[8]) begin
                nxt.yr = r_yr[7:0];
                if (r_yr[8] && cur.cen_en) nxt.cen = ~cur.cen;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_user_copy.sv
`timescale 1ns/1ps
module rtc_user_copy
  import rtc_core_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  rtc_time_t src,
  output rtc_time_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RTC_RESET;
    else if (load) q <= src;
  end
endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core
  import rtc_core_pkg::*;
#(
  parameter int DIV_RATIO = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          hold,
  input  logic          power_fail,
  input  logic          halt_clr,
  output logic          halted
);
  rtc_time_t int_q, int_d, int_adv, usr_q;
  logic      step, halt_q, usr_load;

  rtc_subsec_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(!int_q.stop),
    .clear(wr_en), .step(step)
  );

  rtc_time_adv u_adv (.cur(int_q), .nxt(int_adv));

  always_comb begin
    if (wr_en)     int_d = apply_write(int_q, wr_addr, wr_data);
    else if (step) int_d = int_adv;
    else           int_d = int_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) int_q <= RTC_RESET;
    else        int_q <= int_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          halt_q <= 1'b0;
    else if (power_fail) halt_q <= 1'b1;
    else if (halt_clr)   halt_q <= 1'b0;
  end

  assign usr_load = wr_en || (tick && !hold && !halt_q && !power_fail);

  rtc_user_copy u_usr (
    .clk(clk), .rst_n(rst_n), .load(usr_load), .src(int_d), .q(usr_q)
  );

  assign rd_data = byte_of(usr_q, rd_addr);
  assign halted  = halt_q;
endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
module rtc_core_chk
  import rtc_core_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick,
  input logic      wr_en,
  input logic      hold,
  input logic      power_fail,
  input logic      halt_clr,
  input logic      halt,
  input rtc_time_t int_t,
  input rtc_time_t usr_t
);
  AST_WR_CLEARS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (int_t.hs == 8'h00 && usr_t.hs == 8'h00)); // R1
  AST_WR_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (usr_t == int_t)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(int_t)); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_t.stop && !wr_en) |=> $stable(int_t)); // R8
  AST_XFER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !halt && !power_fail) |=> (usr_t == int_t)); // R9
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(usr_t)); // R10
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    power_fail |=> halt); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !halt_clr) |=> halt); // R11
endmodule

bind rtc_bcd_core rtc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .hold(hold),
  .power_fail(power_fail), .halt_clr(halt_clr), .halt(halt_q),
  .int_t(int_q), .usr_t(usr_q)
);

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/100ps
module sim_rtc_bcd_core;
  localparam int DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       hold = 1'b0, power_fail = 1'b0, halt_clr = 1'b0;
  logic       halted;
  int tests = 0, fails = 0, cyc = 0;
  bit auto_rd = 1'b1;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.DIV_RATIO(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hold(hold),
    .power_fail(power_fail), .halt_clr(halt_clr), .halted(halted)
  );

  // behavioural reference model, binary integers
  int hs, sec, mn, hr, dow, dt, mo, yr, ce, cb, st, dv, mhalt;
  int ub [8];

  function automatic int tobcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int frombcd(int b); return ((b >> 4) & 15) * 10 + (b & 15); endfunction
  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic int mbyte(int i);
    case (i)
      0: return tobcd(hs);
      1: return (st << 7) | tobcd(sec);
      2: return tobcd(mn);
      3: return (ce << 7) | (cb << 6) | tobcd(hr);
      4: return dow;
      5: return tobcd(dt);
      6: return tobcd(mo);
      default: return tobcd(yr);
    endcase
  endfunction
  task automatic snap(); for (int i = 0; i < 8; i++) ub[i] = mbyte(i); endtask
  task automatic advance();
    hs++;
    if (hs < 100) return;
    hs = 0; sec++;
    if (sec < 60) return;
    sec = 0; mn++;
    if (mn < 60) return;
    mn = 0; hr++;
    if (hr < 24) return;
    hr = 0; dow = (dow == 7) ? 1 : dow + 1; dt++;
    if (dt <= mlen(mo, yr)) return;
    dt = 1; mo++;
    if (mo <= 12) return;
    mo = 1; yr++;
    if (yr < 100) return;
    yr = 0; if (ce == 1) cb = 1 - cb;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hs = 0; sec = 0; mn = 0; hr = 0; dow = 1; dt = 1; mo = 1; yr = 0;
      ce = 0; cb = 0; st = 0; dv = 0; mhalt = 0; snap();
    end else begin
      automatic bit xfer = tick && !hold && !mhalt && !power_fail;
      automatic int d = int'(wr_data);
      if (wr_en) begin
        case (int'(wr_addr))
          1: begin st = (d >> 7) & 1; sec = frombcd(d & 8'h7f); end
          2: mn = frombcd(d & 8'h7f);
          3: begin ce = (d >> 7) & 1; cb = (d >> 6) & 1; hr = frombcd(d & 8'h3f); end
          4: dow = d & 7;
          5: dt = frombcd(d & 8'h3f);
          6: mo = frombcd(d & 8'h1f);
          7: yr = frombcd(d);
          default: ;
        endcase
        hs = 0; dv = 0; snap();
      end else begin
        if (tick && st == 0) begin
          dv++;
          if (dv == DIV) begin dv = 0; advance(); end
        end
        if (xfer) snap();
      end
      if (power_fail) mhalt = 1; else if (halt_clr) mhalt = 0;
    end
  end

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && auto_rd) begin
      check("R9 user byte vs model", int'(rd_data), ub[rd_addr]);
      check("R11 halt flag vs model", int'(halted), mhalt);
      rd_addr = rd_addr + 3'd1;
    end
  end

  task automatic peek(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    auto_rd = 1'b0;
    rd_addr = a;
    #0.5;
    check(tag, int'(rd_data), exp);
    auto_rd = 1'b1;
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask
  task automatic set_time(input logic [7:0] y, m, d, w, h, mi, s);
    wr(3'd7, y); wr(3'd6, m); wr(3'd5, d); wr(3'd4, w);
    wr(3'd3, h); wr(3'd2, mi); wr(3'd1, s);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    peek(3'd0, 8'h00, "R12 hundredths"); peek(3'd3, 8'h00, "R12 hours/century");
    peek(3'd4, 8'h01, "R12 day"); peek(3'd5, 8'h01, "R12 date");
    peek(3'd6, 8'h01, "R12 month"); check("R12 halt", int'(halted), 0);
    // R1 / R2
    wr(3'd0, 8'h55); peek(3'd0, 8'h00, "R1 addr0 data ignored");
    wr(3'd1, 8'h30); peek(3'd1, 8'h30, "R2 readback");
    // R3 divider
    ticks(DIV - 1); peek(3'd0, 8'h00, "R3 before step");
    ticks(1); peek(3'd0, 8'h01, "R3 first step");
    // R4 / R7 full rollover with century enable
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'hA3, 8'h59, 8'h59);
    ticks(100 * DIV);
    peek(3'd1, 8'h00, "R4 seconds"); peek(3'd2, 8'h00, "R4 minutes");
    peek(3'd4, 8'h01, "R4 day of week wrap");
    peek(3'd3, 8'hC0, "R7 century toggled"); peek(3'd7, 8'h00, "R7 year wrap");
    peek(3'd6, 8'h01, "R5 month wrap"); peek(3'd5, 8'h01, "R5 date wrap");
    // R7 century disabled
    set_time(8'h99, 8'h12, 8'h31, 8'h03, 8'h63, 8'h59, 8'h59);
    ticks(100 * DIV); peek(3'd3, 8'h40, "R7 century held");
    // R5 30- and 31-day months
    set_time(8'h00, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(100 * DIV); peek(3'd5, 8'h01, "R5 Apr 30 wrap"); peek(3'd6, 8'h05, "R5 to May");
    set_time(8'h00, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(100 * DIV); peek(3'd5, 8'h31, "R5 Jan 31 exists");
    // R6 February
    set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(100 * DIV); peek(3'd5, 8'h29, "R6 leap 24");
    set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(100 * DIV); peek(3'd5, 8'h01, "R6 non-leap 23"); peek(3'd6, 8'h03, "R6 March");
    set_time(8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(100 * DIV); peek(3'd5, 8'h29, "R6 leap 00");
    // R8 stop
    wr(3'd1, 8'h90); ticks(5 * DIV);
    peek(3'd1, 8'h90, "R8 stopped seconds"); peek(3'd0, 8'h00, "R8 stopped hundredths");
    wr(3'd1, 8'h10); ticks(DIV); peek(3'd0, 8'h01, "R8 resumed");
    // R10 hold
    wr(3'd1, 8'h00);
    @(negedge clk); hold = 1'b1;
    ticks(3 * DIV); peek(3'd0, 8'h00, "R10 frozen under hold");
    @(negedge clk); hold = 1'b0;
    ticks(1); peek(3'd0, 8'h03, "R10 refresh after release");
    // R11 halt
    wr(3'd1, 8'h00);
    @(negedge clk); power_fail = 1'b1;
    @(negedge clk); power_fail = 1'b0;
    check("R11 halt set", int'(halted), 1);
    ticks(2 * DIV); peek(3'd0, 8'h00, "R11 no transfer while halted");
    wr(3'd2, 8'h05); peek(3'd2, 8'h05, "R2 write visible while halted");
    @(negedge clk); halt_clr = 1'b1;
    @(negedge clk); halt_clr = 1'b0;
    check("R11 halt cleared", int'(halted), 0);
    ticks(DIV); peek(3'd0, 8'h01, "R11 transfer resumes");
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule